// File: doc/BRIEF.md
# Burst-Throttled DMA Channel Arbiter

This block decides which of four internal DMA requesters owns a single shared bus-master port: the receive data channel, the transmit data channel, the command-unit channel and the receive-unit channel. A channel raises its request, receives a one-hot grant and keeps it until it pulses its done line. The next owner is picked in rotating order, starting with the channel after the one that last held the port.

The two data channels can be throttled. Each has a 7-bit limit, and one limit unit stands for four data cycles on the bus. While a throttled channel holds the port, the arbiter counts data-phase strobes. Once the count reaches the limit, and only while some other channel is waiting, the arbiter raises a terminate request. The owner then finishes its current cycle, drops its request and pulses done, and the port passes to the waiting channel. A lone channel may burst for as long as it likes. With the shared limit enable clear, neither data channel is ever cut short. A preempted channel requests again later and starts over with a fresh count.

The block also picks the write command type. Receive data writes use memory-write-and-invalidate only when both the local enable and the bus permission bit are set.

Top module: `dma_burst_arbiter`

## Requirements
- R1: At most one grant bit is high. Channel bits are: bit 0 receive data, bit 1 transmit data, bit 2 command unit, bit 3 receive unit. A request seen while the port is idle is granted at the next clock edge. A grant stays unchanged until its owner pulses its done bit. The port then goes idle at the next edge if no other channel requests.
- R2: The next owner is the first requesting channel in rotating index order, starting one past the last owner. After reset, channel 0 has first priority.
- R3: The data-cycle count restarts at 0 on every new grant and increases by one for each strobe sampled during the grant. The threshold is 4 times the limit when the limit is 1 to 127, and 1 when the limit is 0. Preempt is high in the cycle after the edge that samples the strobe that brings the count to the threshold, when the enable is set and another channel requests.
- R4: Preempt is never high while no channel other than the owner requests, whatever the count.
- R5: With the limit enable clear, preempt stays low for every channel and count.
- R6: Preempt never asserts while the command-unit or receive-unit channel owns the port.
- R7: Once raised, preempt stays high through further strobes as long as a rival waits. When the preempted owner pulses done, the grant moves at that edge to the first requesting channel after it in rotating order.
- R8: A channel that was preempted and is granted again counts from zero. It is not preemptible again until it has seen a full threshold of new strobes.
- R9: The write-type select is 1 only while the receive data channel holds the grant and both the local MWI enable and the bus MWI permission are 1. Otherwise it is 0.
- R10: During reset the grant, preempt and write-type outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chReq | input | 4 | Per-channel request |
| chDone | input | 4 | Per-channel end-of-transfer pulse |
| dataStrobe | input | 1 | One pulse per bus data phase |
| rxLimit | input | 7 | Receive data limit, in units of 4 data cycles |
| txLimit | input | 7 | Transmit data limit, in units of 4 data cycles |
| limitEn | input | 1 | Enables throttling for both data channels |
| mwiLocalEn | input | 1 | Local memory-write-and-invalidate enable |
| mwiBusEn | input | 1 | Bus command-register MWI permission |
| grant | output | 4 | One-hot grant |
| preempt | output | 1 | Terminate request to the current owner |
| wrCmdSel | output | 1 | 1 selects memory-write-and-invalidate, 0 selects plain write |

## Verification
Grants change one edge after the request or done input that causes them. The bench drives inputs on the falling edge and reads the grant on the following falling edge. Preempt and the write-type select are combinational on the registered grant and count, so each strobe is checked on the falling edge right after the rising edge that counted it. The sweep covers limit values 0 to 20 and 127 on every channel, with the enable on and off and with a rival present or absent. For each strobe, the expected preempt level is computed in the bench as count >= threshold together with the enable, throttle and rival conditions.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  parameter int NUM_CH = 4;
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int RX_CH = 0;
  localparam int TX_CH = 1;

  typedef logic [IDX_W-1:0] chIdxT;

  // Strobes from control to the datapath
  typedef struct packed {
    logic clearCnt;   // new grant issued this edge
    logic countEn;    // data phase under an active grant
  } ctrlStrobeT;
endpackage

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int LIMIT_W = 7,
  parameter logic [NUM_CH-1:0] THROTTLE_MASK = 4'b0011
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobeT                     strobes,
  input  chIdxT                          activeIdx,
  input  logic [NUM_CH-1:0][LIMIT_W-1:0] limitTab,
  input  logic                           limitEn,
  output logic                           limitHit
);
  localparam int CNT_W = LIMIT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cycCnt;
  logic [NUM_CH-1:0][CNT_W-1:0] thrTab;

  // Per-channel threshold: four data cycles per unit, zero means one cycle
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_thr
    always_comb begin
      if (limitTab[ch] == '0) thrTab[ch] = CNT_W'(1);
      else                    thrTab[ch] = {limitTab[ch], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (strobes.clearCnt) begin
      cycCnt <= '0;
    end else if (strobes.countEn && cycCnt != CNT_MAX) begin
      cycCnt <= cycCnt + CNT_W'(1);
    end
  end

  always_comb begin
    limitHit = limitEn && THROTTLE_MASK[activeIdx] && (cycCnt >= thrTab[activeIdx]);
  end
endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chDone,
  input  logic              dataStrobe,
  input  logic              limitHit,
  input  logic              mwiLocalEn,
  input  logic              mwiBusEn,
  output logic [NUM_CH-1:0] grant,
  output chIdxT             activeIdx,
  output ctrlStrobeT        strobes,
  output logic              preempt,
  output logic              wrCmdSel
);
  logic [NUM_CH-1:0] grantQ;
  logic              busy;
  chIdxT             ownerIdx;
  chIdxT             lastIdx;
  logic              doneActive;
  logic              handoff;
  logic [NUM_CH-1:0] ownerMask;
  logic [NUM_CH-1:0] candidates;
  chIdxT             pickIdx;
  logic              pickValid;
  logic              rivals;

  always_comb begin
    ownerMask  = grantQ;
    doneActive = busy && chDone[ownerIdx];
    handoff    = !busy || doneActive;
    candidates = chReq & ~(doneActive ? ownerMask : '0);
  end

  // Rotating pick: scan downward so the nearest channel after lastIdx wins
  always_comb begin
    pickIdx   = lastIdx;
    pickValid = 1'b0;
    for (int k = NUM_CH; k >= 1; k--) begin
      if (candidates[(int'(lastIdx) + k) % NUM_CH]) begin
        pickIdx   = chIdxT'((int'(lastIdx) + k) % NUM_CH);
        pickValid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ   <= '0;
      busy     <= 1'b0;
      ownerIdx <= '0;
      lastIdx  <= chIdxT'(NUM_CH - 1);
    end else if (handoff) begin
      if (pickValid) begin
        grantQ   <= NUM_CH'(1) << pickIdx;
        busy     <= 1'b1;
        ownerIdx <= pickIdx;
        lastIdx  <= pickIdx;
      end else begin
        grantQ <= '0;
        busy   <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.clearCnt = handoff && pickValid;
    strobes.countEn  = busy && dataStrobe;
    rivals           = |(chReq & ~grantQ);
    preempt          = busy && limitHit && rivals;
    wrCmdSel         = grantQ[RX_CH] && mwiLocalEn && mwiBusEn;
    grant            = grantQ;
    activeIdx        = ownerIdx;
  end
endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter
  import dma_arb_pkg::*;
#(
  parameter int LIMIT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chDone,
  input  logic              dataStrobe,
  input  logic [LIMIT_W-1:0] rxLimit,
  input  logic [LIMIT_W-1:0] txLimit,
  input  logic              limitEn,
  input  logic              mwiLocalEn,
  input  logic              mwiBusEn,
  output logic [NUM_CH-1:0] grant,
  output logic              preempt,
  output logic              wrCmdSel
);
  localparam logic [NUM_CH-1:0] THROTTLE_MASK =
    (NUM_CH'(1) << RX_CH) | (NUM_CH'(1) << TX_CH);

  logic [NUM_CH-1:0][LIMIT_W-1:0] limitTab;
  ctrlStrobeT strobes;
  chIdxT      activeIdx;
  logic       limitHit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lim
    if (ch == RX_CH) begin : g_rx
      assign limitTab[ch] = rxLimit;
    end else if (ch == TX_CH) begin : g_tx
      assign limitTab[ch] = txLimit;
    end else begin : g_free
      assign limitTab[ch] = '0;
    end
  end

  dma_arb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chReq      (chReq),
    .chDone     (chDone),
    .dataStrobe (dataStrobe),
    .limitHit   (limitHit),
    .mwiLocalEn (mwiLocalEn),
    .mwiBusEn   (mwiBusEn),
    .grant      (grant),
    .activeIdx  (activeIdx),
    .strobes    (strobes),
    .preempt    (preempt),
    .wrCmdSel   (wrCmdSel)
  );

  dma_arb_datapath #(
    .LIMIT_W       (LIMIT_W),
    .THROTTLE_MASK (THROTTLE_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .activeIdx (activeIdx),
    .limitTab  (limitTab),
    .limitEn   (limitEn),
    .limitHit  (limitHit)
  );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker
  import dma_arb_pkg::*;
#(
  parameter logic [NUM_CH-1:0] THROTTLE_MASK = 4'b0011
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chReq,
  input logic [NUM_CH-1:0] chDone,
  input logic [NUM_CH-1:0] grant,
  input logic              preempt,
  input logic              limitEn,
  input logic              wrCmdSel,
  input logic              mwiLocalEn,
  input logic              mwiBusEn
);
  // R1
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R1
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|grant) && !(|(chDone & grant))) |=> (grant == $past(grant)));

  // R4
  preempt_rival_chk: assert property (@(posedge clk) disable iff (!rstN)
    preempt |-> ((chReq & ~grant) != '0));

  // R5
  preempt_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    preempt |-> limitEn);

  // R6
  preempt_throttled_chk: assert property (@(posedge clk) disable iff (!rstN)
    preempt |-> ((grant & THROTTLE_MASK) != '0));

  // R9
  mwi_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCmdSel |-> (grant[RX_CH] && mwiLocalEn && mwiBusEn));
endmodule

bind dma_burst_arbiter dma_arb_checker #(.THROTTLE_MASK(THROTTLE_MASK)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chReq      (chReq),
  .chDone     (chDone),
  .grant      (grant),
  .preempt    (preempt),
  .limitEn    (limitEn),
  .wrCmdSel   (wrCmdSel),
  .mwiLocalEn (mwiLocalEn),
  .mwiBusEn   (mwiBusEn)
);

// File: tb/sim_dma_burst_arbiter.sv
module sim_dma_burst_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] chReq = '0;
  logic [3:0] chDone = '0;
  logic dataStrobe = 1'b0;
  logic [LIMIT_W-1:0] rxLimit = '0;
  logic [LIMIT_W-1:0] txLimit = '0;
  logic limitEn = 1'b0;
  logic mwiLocalEn = 1'b0;
  logic mwiBusEn = 1'b0;
  logic [3:0] grant;
  logic preempt;
  logic wrCmdSel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_burst_arbiter #(.LIMIT_W(LIMIT_W)) u0 (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chDone(chDone),
    .dataStrobe(dataStrobe), .rxLimit(rxLimit), .txLimit(txLimit),
    .limitEn(limitEn), .mwiLocalEn(mwiLocalEn), .mwiBusEn(mwiBusEn),
    .grant(grant), .preempt(preempt), .wrCmdSel(wrCmdSel)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // End the current owner's transfer
  task automatic finish(input int ch);
    chDone = 4'(1 << ch);
    chReq  = chReq & ~4'(1 << ch);
    tick();
    chDone = '0;
  endtask

  task automatic burst(input int ch, input int lim, input bit en, input bit rival);
    int rv, thr;
    bit thrCh;
    string tag;
    rv = (ch + 2) % 4;
    thr = (lim == 0) ? 1 : lim * 4;
    thrCh = (ch < 2);
    rxLimit = LIMIT_W'(lim);
    txLimit = LIMIT_W'(lim);
    limitEn = en;
    chReq = 4'(1 << ch);
    tick();
    chk("R1", "grant on lone request", int'(grant), 1 << ch);
    if (rival) chReq = chReq | 4'(1 << rv);
    dataStrobe = 1'b1;
    for (int n = 1; n <= thr + 2; n++) begin
      tick();
      if (!thrCh) tag = "R6";
      else if (!en) tag = "R5";
      else if (!rival) tag = "R4";
      else if (n > thr) tag = "R7";
      else tag = "R3";
      chk(tag, "preempt level", int'(preempt), (en && thrCh && rival && n >= thr) ? 1 : 0);
    end
    dataStrobe = 1'b0;
    chk("R1", "grant held through burst", int'(grant), 1 << ch);
    finish(ch);
    if (rival) begin
      chk("R7", "handoff to waiting channel", int'(grant), 1 << rv);
      finish(rv);
    end
    chk("R1", "idle after last done", int'(grant), 0);
  endtask

  initial begin
    tick();
    chReq = 4'hF;
    mwiLocalEn = 1'b1;
    mwiBusEn = 1'b1;
    limitEn = 1'b1;
    dataStrobe = 1'b1;
    tick(); tick();
    chk("R10", "grant in reset", int'(grant), 0);
    chk("R10", "preempt in reset", int'(preempt), 0);
    chk("R10", "wrCmdSel in reset", int'(wrCmdSel), 0);
    dataStrobe = 1'b0;
    limitEn = 1'b0;
    rstN = 1'b1;

    // R2: rotation from reset, all requesting
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2", "rotation order from reset", int'(grant), 1 << i);
      chDone = 4'(1 << i);
      chReq  = chReq & ~4'(1 << i);
    end
    tick();
    chDone = '0;
    chk("R1", "idle after rotation", int'(grant), 0);
    chReq = 4'b0010;
    tick();
    chk("R2", "lone tx", int'(grant), 2);
    finish(1);
    chReq = 4'b1101;
    tick();
    chk("R2", "first after last owner 1", int'(grant), 4);
    finish(2);
    chk("R2", "then channel 3", int'(grant), 8);
    finish(3);
    chk("R2", "wrap to channel 0", int'(grant), 1);
    finish(0);

    // R9: write type select
    mwiLocalEn = 1'b0; mwiBusEn = 1'b0;
    tick();
    chReq = 4'b0001;
    tick();
    for (int b = 0; b < 4; b++) begin
      mwiLocalEn = b[0];
      mwiBusEn = b[1];
      #1;
      chk("R9", "rx write type", int'(wrCmdSel), (b == 3) ? 1 : 0);
    end
    finish(0);
    chk("R9", "idle write type", int'(wrCmdSel), 0);
    chReq = 4'b0010;
    tick();
    chk("R9", "tx write type", int'(wrCmdSel), 0);
    finish(1);

    // R7 and R8: preempt handoff order and fresh count on resume
    rxLimit = 2; limitEn = 1'b1;
    chReq = 4'b0001;
    tick();
    chReq = 4'b1011;
    dataStrobe = 1'b1;
    for (int n = 1; n <= 8; n++) tick();
    dataStrobe = 1'b0;
    chk("R3", "preempt at 8 strobes", int'(preempt), 1);
    finish(0);
    chk("R7", "next after rx is tx", int'(grant), 2);
    finish(1);
    chk("R7", "then receive unit", int'(grant), 8);
    chReq = chReq | 4'b0001;
    finish(3);
    chk("R8", "rx regranted", int'(grant), 1);
    chReq = chReq | 4'b0100;
    dataStrobe = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      tick();
      chk("R8", "fresh count after resume", int'(preempt), (n >= 8) ? 1 : 0);
    end
    dataStrobe = 1'b0;
    finish(0);
    finish(2);

    // Sweep: limits, channels, enable, rival
    for (int ch = 0; ch < 4; ch++)
      for (int e = 0; e < 2; e++)
        for (int r = 0; r < 2; r++) begin
          for (int lim = 0; lim <= 20; lim++) burst(ch, lim, e[0], r[0]);
          burst(ch, 127, e[0], r[0]);
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule